// File: doc/BRIEF.md
# Pipelined YCbCr to RGB Converter

This block turns one studio-range YCbCr pixel per clock into an RGB pixel. Each clock it takes an 8-bit luma sample and two 8-bit chroma samples and removes the fixed offsets. It then forms three weighted sums with fixed-point coefficients and rounds each sum to an integer. Finally it clamps each channel to the 0 to 255 code range.

The datapath has three register stages: after offset removal, after the multiply-add, and after saturation. The output therefore trails the input by a constant three clocks, and a new pixel can enter on every cycle. There is no valid or handshake signalling. The caller aligns its data with the fixed latency, which the package exports as `PIPE_LAT`.

Top module: `ycc_to_rgb`

## Requirements
- R1: The block subtracts 16 from luma and 128 from each chroma sample and treats the results as signed values. A luma below 16 gives a negative term. Y=16 with Cb=Cr=128 gives 0 on all three channels, and Y=17 with Cb=Cr=128 gives 1 on all three channels.
- R2: Red stays within 2 codes of 1.164·(Y−16) + 1.596·(Cr−128), after that value is clamped to 0..255.
- R3: Green stays within 2 codes of 1.164·(Y−16) − 0.813·(Cr−128) − 0.392·(Cb−128), after that value is clamped to 0..255.
- R4: Blue stays within 2 codes of 1.164·(Y−16) + 2.017·(Cb−128), after that value is clamped to 0..255.
- R5: A channel whose real result is negative outputs 0.
- R6: A channel whose real result exceeds 255 outputs 255. This covers all inputs at 255, and Y=255 with Cb=Cr=0.
- R7: A pixel presented before rising edge k appears on the outputs after rising edge k+2, which is three edges counting edge k. A new pixel is accepted on every edge. A one-cycle input pulse gives a one-cycle output pulse.
- R8: While rst_ni is low, all three outputs read 0.
- R9: When Cb=Cr=128, the three outputs are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference chroma sample |
| cr_i | input | 8 | Red-difference chroma sample |
| r_o | output | 8 | Red channel |
| g_o | output | 8 | Green channel |
| b_o | output | 8 | Blue channel |

## Verification
The bench starts with directed corner cases and then runs a long back-to-back random stream. The corners are both all-255 and all-zero inputs, Y=255 with zero chroma, luma just at and above its offset, and neutral chroma.

Several wrong designs would show up at the ports:
- Treating the offset-removed values as unsigned, or leaving out the clamp, wraps a red or blue result near 255 around to a small code.
- A narrow accumulator overflows in green when both chroma samples are 0.
- A coefficient of the wrong sign or size pushes the random stream outside the 2-code band.
- A missing or extra register stage misaligns every streamed pixel, and the one-cycle pulse test catches it directly.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int NUM_CH   = 3;
  localparam int PIPE_LAT = 3;
  localparam int CH_R = 0;
  localparam int CH_G = 1;
  localparam int CH_B = 2;

  // offsets for 8-bit samples, scaled up for wider pixels
  localparam int LUMA_OFS_8   = 16;
  localparam int CHROMA_OFS_8 = 128;

  // coefficients in thousandths: src 0 = luma, 1 = Cb, 2 = Cr
  function automatic int coef_milli(input int ch, input int src);
    int c;
    c = 0;
    if (src == 0) c = 1164;
    else if (ch == CH_R && src == 2) c = 1596;
    else if (ch == CH_G && src == 1) c = -392;
    else if (ch == CH_G && src == 2) c = -813;
    else if (ch == CH_B && src == 1) c = 2017;
    return c;
  endfunction

  // round-to-nearest scaling of a thousandths value to FRAC fraction bits
  function automatic int scale_coef(input int milli, input int frac);
    int mag;
    mag = (milli < 0) ? -milli : milli;
    mag = ((mag << frac) + 500) / 1000;
    return (milli < 0) ? -mag : mag;
  endfunction
endpackage

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage
  import ycc_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int OFS_W = PIX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PIX_W-1:0]        y_i,
  input  logic [PIX_W-1:0]        cb_i,
  input  logic [PIX_W-1:0]        cr_i,
  output logic signed [OFS_W-1:0] y_o,
  output logic signed [OFS_W-1:0] cb_o,
  output logic signed [OFS_W-1:0] cr_o
);
  localparam int SCALE  = 1 << (PIX_W - 8);
  localparam int Y_OFS  = LUMA_OFS_8 * SCALE;
  localparam int C_OFS  = CHROMA_OFS_8 * SCALE;
  localparam logic signed [OFS_W-1:0] Y_OFS_S = OFS_W'(Y_OFS);
  localparam logic signed [OFS_W-1:0] C_OFS_S = OFS_W'(C_OFS);

  logic signed [OFS_W-1:0] y_d, cb_d, cr_d;

  always_comb begin
    y_d  = $signed({1'b0, y_i})  - Y_OFS_S;
    cb_d = $signed({1'b0, cb_i}) - C_OFS_S;
    cr_d = $signed({1'b0, cr_i}) - C_OFS_S;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o  <= '0;
      cb_o <= '0;
      cr_o <= '0;
    end else begin
      y_o  <= y_d;
      cb_o <= cb_d;
      cr_o <= cr_d;
    end
  end

  AST_LUMA_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(y_i) < Y_OFS) |=> (y_o < 0)); // R1
  AST_CHROMA_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cb_i) >= C_OFS) |=> (cb_o >= 0)); // R1
endmodule

// File: rtl/ycc_matrix_stage.sv
module ycc_matrix_stage
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 10,
  localparam int OFS_W = PIX_W + 1,
  localparam int ACC_W = OFS_W + FRAC_W + 4,
  localparam int SUM_W = ACC_W - FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OFS_W-1:0] y_i,
  input  logic signed [OFS_W-1:0] cb_i,
  input  logic signed [OFS_W-1:0] cr_i,
  output logic signed [SUM_W-1:0] sum_o [NUM_CH]
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC_W - 1));
  // worst case magnitude is below 4x full scale
  localparam int BOUND = 4 << PIX_W;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_row
    localparam int KY  = scale_coef(coef_milli(k, 0), FRAC_W);
    localparam int KCB = scale_coef(coef_milli(k, 1), FRAC_W);
    localparam int KCR = scale_coef(coef_milli(k, 2), FRAC_W);

    logic signed [ACC_W-1:0] acc, rnd;

    always_comb begin
      acc = ACC_W'(KY)  * ACC_W'(y_i)
          + ACC_W'(KCB) * ACC_W'(cb_i)
          + ACC_W'(KCR) * ACC_W'(cr_i);
      rnd = (acc + HALF) >>> FRAC_W;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_o[k] <= '0;
      else         sum_o[k] <= rnd[SUM_W-1:0];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sum_o[k]) < BOUND) && (int'(sum_o[k]) > -BOUND)); // R2
  end
endmodule

// File: rtl/ycc_clamp_stage.sv
module ycc_clamp_stage #(
  parameter int PIX_W = 8,
  parameter int SUM_W = 13
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [PIX_W-1:0]        pix_o
);
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(PIX_MAX);

  logic [PIX_W-1:0] pix_d;

  always_comb begin
    if (sum_i < 0)       pix_d = '0;
    else if (sum_i > HI) pix_d = '1;
    else                 pix_d = sum_i[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= pix_d;
  end

  AST_CLAMP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_i < 0) |=> (pix_o == '0)); // R5
  AST_CLAMP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_i > HI) |=> (int'(pix_o) == PIX_MAX)); // R6
endmodule

// File: rtl/ycc_to_rgb.sv
module ycc_to_rgb
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] cb_i,
  input  logic [PIX_W-1:0] cr_i,
  output logic [PIX_W-1:0] r_o,
  output logic [PIX_W-1:0] g_o,
  output logic [PIX_W-1:0] b_o
);
  localparam int OFS_W = PIX_W + 1;
  localparam int ACC_W = OFS_W + FRAC_W + 4;
  localparam int SUM_W = ACC_W - FRAC_W;
  localparam logic [PIX_W-1:0] C_MID = PIX_W'(CHROMA_OFS_8 << (PIX_W - 8));

  logic signed [OFS_W-1:0] y_s, cb_s, cr_s;
  logic signed [SUM_W-1:0] sum  [NUM_CH];
  logic [PIX_W-1:0]        pix  [NUM_CH];

  ycc_offset_stage #(.PIX_W(PIX_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .y_i    (y_i),
    .cb_i   (cb_i),
    .cr_i   (cr_i),
    .y_o    (y_s),
    .cb_o   (cb_s),
    .cr_o   (cr_s)
  );

  ycc_matrix_stage #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .y_i    (y_s),
    .cb_i   (cb_s),
    .cr_i   (cr_s),
    .sum_o  (sum)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    ycc_clamp_stage #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_clamp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sum_i  (sum[k]),
      .pix_o  (pix[k])
    );
  end

  assign r_o = pix[CH_R];
  assign g_o = pix[CH_G];
  assign b_o = pix[CH_B];

  AST_GREY_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cb_i == C_MID && cr_i == C_MID) |=> ##2 (r_o == g_o && g_o == b_o)); // R9
endmodule

// File: tb/ycc_to_rgb_tb.sv
`timescale 1ns/1ps
module ycc_to_rgb_tb;
  import ycc_pkg::*;

  localparam int N_RAND = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] y, cb, cr;
  logic [7:0] r, g, b;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ycc_to_rgb u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .y_i(y), .cb_i(cb), .cr_i(cr),
    .r_o(r), .g_o(g), .b_o(b)
  );

  function automatic real raw_val(input int ch, input int yy, input int bb, input int rr);
    real ly, lb, lr;
    ly = real'(yy - 16); lb = real'(bb - 128); lr = real'(rr - 128);
    if (ch == CH_R) return 1.164 * ly + 1.596 * lr;
    if (ch == CH_G) return 1.164 * ly - 0.813 * lr - 0.392 * lb;
    return 1.164 * ly + 2.017 * lb;
  endfunction

  function automatic real clamp_val(input real v);
    if (v < 0.0) return 0.0;
    if (v > 255.0) return 255.0;
    return v;
  endfunction

  task automatic chk_near(input string tag, input int act, input real exp_v);
    real d;
    n_chk++;
    d = real'(act) - exp_v;
    if (d > 2.0 || d < -2.0) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %f", tag, act, exp_v);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic chk_pixel(input int yy, input int bb, input int rr);
    int act [NUM_CH];
    act[CH_R] = int'(r); act[CH_G] = int'(g); act[CH_B] = int'(b);
    for (int k = 0; k < NUM_CH; k++) begin
      real v;
      string tag;
      v = raw_val(k, yy, bb, rr);
      if (v < 0.0)        tag = "R5";
      else if (v > 255.0) tag = "R6";
      else if (k == CH_R) tag = "R2";
      else if (k == CH_G) tag = "R3";
      else                tag = "R4";
      chk_near(tag, act[k], clamp_val(v));
    end
    if (bb == 128 && rr == 128) begin
      chk_eq("R9 g", int'(g), int'(r));
      chk_eq("R9 b", int'(b), int'(r));
    end
  endtask

  // drive and hold, then check exact grey level once settled
  task automatic settle_grey(input int yy, input int exp_v);
    y = 8'(yy); cb = 8'd128; cr = 8'd128;
    repeat (PIPE_LAT) @(negedge clk);
    chk_eq("R1 r", int'(r), exp_v);
    chk_eq("R1 g", int'(g), exp_v);
    chk_eq("R1 b", int'(b), exp_v);
  endtask

  int py [PIPE_LAT];
  int pb [PIPE_LAT];
  int pr [PIPE_LAT];
  bit pv [PIPE_LAT];

  task automatic stream_step(input bit vld, input int yy, input int bb, input int rr);
    if (pv[PIPE_LAT-1]) chk_pixel(py[PIPE_LAT-1], pb[PIPE_LAT-1], pr[PIPE_LAT-1]);
    for (int i = PIPE_LAT - 1; i > 0; i--) begin
      py[i] = py[i-1]; pb[i] = pb[i-1]; pr[i] = pr[i-1]; pv[i] = pv[i-1];
    end
    py[0] = yy; pb[0] = bb; pr[0] = rr; pv[0] = vld;
    y = 8'(yy); cb = 8'(bb); cr = 8'(rr);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    y = 8'd200; cb = 8'd10; cr = 8'd250;
    // R8: outputs stay zero under reset even with live inputs
    repeat (3) @(negedge clk);
    chk_eq("R8 r", int'(r), 0);
    chk_eq("R8 g", int'(g), 0);
    chk_eq("R8 b", int'(b), 0);
    rst_ni = 1'b1;

    settle_grey(16, 0);  // R1
    settle_grey(17, 1);  // R1
    settle_grey(15, 0);  // R1 negative luma term, clamps per R5

    // R7: one-cycle white pulse between black pixels
    y = 8'd16; cb = 8'd128; cr = 8'd128;
    repeat (PIPE_LAT + 1) @(negedge clk);
    y = 8'd235;
    @(negedge clk);
    y = 8'd16;
    chk_eq("R7 edge+1", int'(r), 0);
    @(negedge clk);
    chk_eq("R7 edge+2", int'(g), 0);
    @(negedge clk);
    chk_eq("R7 edge+3 r", int'(r), 255);
    chk_eq("R7 edge+3 b", int'(b), 255);
    @(negedge clk);
    chk_eq("R7 pulse end", int'(r), 0);

    for (int i = 0; i < PIPE_LAT; i++) pv[i] = 0;
    // corner cases, back to back (R6, R5, R9)
    stream_step(1, 255, 255, 255);
    stream_step(1, 255, 0, 0);
    stream_step(1, 0, 0, 0);
    stream_step(1, 0, 255, 255);
    stream_step(1, 255, 0, 255);
    stream_step(1, 255, 255, 0);
    stream_step(1, 235, 240, 240);
    stream_step(1, 16, 16, 16);
    stream_step(1, 200, 128, 128);
    stream_step(1, 255, 128, 128);
    for (int n = 0; n < N_RAND; n++)
      stream_step(1, int'($urandom_range(255)), int'($urandom_range(255)),
                  int'($urandom_range(255)));
    for (int i = 0; i < PIPE_LAT; i++) stream_step(0, 16, 128, 128);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule